// File: doc/BRIEF.md
# Transmit Power Amplifier Start-up Sequencer

This block orders the enables that bring a radio transmitter up. It idles in a synthesizer-ready state. A rising edge on the trigger input starts a transmission and moves it to the busy-transmit state. From there it counts microsecond ticks toward a fixed modulation start 16 µs after the trigger. The same window gives the synthesizer time to settle on the transmit frequency.

Before modulation starts, the internal PA buffer and the internal PA are each switched on at a lead time of their own. Each lead time comes from a 2-bit field that is captured when the transmission starts. An external amplifier is driven through a complementary pin pair. A frame-done input shuts every enable off at once and sends the sequencer back to the ready state.

Top module: `txpa_sequencer`

## Requirements
- R1: After reset, `state_o` is 0 (ready). `pa_buf_en_o`, `pa_en_o` and `mod_en_o` are low, and the external pair is idle (`ext_pa_p_o`=0, `ext_pa_n_o`=1).
- R2: When `state_o` is 0, a rising edge on `trig_i` sets `state_o` to 1 (busy) after the next clock edge. A rising edge is `trig_i` high in a cycle after a cycle in which it was low.
- R3: The count k is the number of `us_tick_i` pulses seen at clock edges while `state_o` is 1. It is zero on entry and saturates at 16. `mod_en_o` is high exactly when k ≥ 16.
- R4: `pa_buf_en_o` is high in busy exactly when k ≥ 16 − 2·(B+1), where B is the value of `buf_lead_i`. The field values 0 to 3 mean 2, 4, 6 and 8 µs of lead.
- R5: `pa_en_o` is high in busy exactly when k ≥ 16 − 2·(P+1), where P is the value of `pa_lead_i`, with the same encoding as R4.
- R6: B and P are taken from the value of each field on the clock edge that starts the transmission. Changing either field while busy has no effect on the enables.
- R7: `ext_pa_p_o` equals `pa_en_o` and `ext_pa_n_o` is its complement. The pins are never equal.
- R8: While `frame_done_i` is high in busy, `pa_buf_en_o`, `pa_en_o` and `mod_en_o` are low in that same cycle. `state_o` returns to 0 after the clock edge.
- R9: A trigger edge while busy is ignored, and so is a trigger edge in the cycle that `frame_done_i` ends the frame. A trigger held high across the return to ready does not restart the sequence.
- R10: Ticks seen while ready are not counted. After modulation starts, all enables stay high until `frame_done_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick_i | input | 1 | One-cycle pulse each microsecond |
| trig_i | input | 1 | Transmit trigger level; a rising edge starts a transmission |
| frame_done_i | input | 1 | End of frame; drops enables and returns to ready |
| buf_lead_i | input | 2 | PA buffer lead-time code |
| pa_lead_i | input | 2 | PA lead-time code |
| state_o | output | 1 | 0 = synthesizer ready, 1 = busy transmitting |
| pa_buf_en_o | output | 1 | Internal PA buffer enable |
| pa_en_o | output | 1 | Internal PA enable |
| mod_en_o | output | 1 | Modulation running |
| ext_pa_p_o | output | 1 | External PA control, high when active |
| ext_pa_n_o | output | 1 | External PA control, low when active |

## Verification
Two events can land in the same cycle: a frame-done pulse and a fresh trigger edge. The bench provokes this by lowering the trigger during a transmission, then raising it on the very cycle that frame-done is asserted. It checks in that cycle that every enable is already low. It then checks that the state returns to ready and stays there while the trigger is held high, and that only a later, separate edge starts a new transmission. The bench also sweeps all sixteen lead-time pairs. It compares each enable against the thresholds after every tick, with the lead fields disturbed in the middle of the ramp.

// File: rtl/txpa_pkg.sv
package txpa_pkg;
   typedef enum logic {
      ST_PLL_READY = 1'b0,
      ST_BUSY_TX   = 1'b1
   } txpa_state_e;
endpackage

// File: rtl/txpa_edge.sv
module txpa_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic level_i,
   output logic rise_o
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level_i;
   end

   assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/txpa_tick_count.sv
module txpa_tick_count #(
   parameter int unsigned LIMIT = 16,
   parameter int unsigned CNT_W = $clog2(LIMIT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             run_i,
   input  logic             tick_i,
   output logic [CNT_W-1:0] count_o,
   output logic             done_o
);
   localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

   if (LIMIT < 1) begin : g_bad_limit
      $error("txpa_tick_count: LIMIT must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cnt_q <= '0;
      else if (clear_i)                   cnt_q <= '0;
      else if (run_i && tick_i && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
   end

   assign count_o = cnt_q;
   assign done_o  = (cnt_q == LIM);

   assert_count_sat_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LIM);
   assert_count_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/txpa_lead_gate.sv
module txpa_lead_gate #(
   parameter int unsigned LEAD_W       = 2,
   parameter int unsigned STEP_US      = 2,
   parameter int unsigned MOD_DELAY_US = 16,
   parameter int unsigned CNT_W        = $clog2(MOD_DELAY_US + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [LEAD_W-1:0] lead_i,
   input  logic [CNT_W-1:0]  count_i,
   input  logic              active_i,
   input  logic              kill_i,
   output logic              en_o
);
   localparam int unsigned MAX_LEAD = STEP_US * (2 ** LEAD_W);

   if (MAX_LEAD > MOD_DELAY_US) begin : g_bad_lead
      $error("txpa_lead_gate: largest lead exceeds modulation delay");
   end

   logic [LEAD_W-1:0] lead_q;
   logic [CNT_W-1:0]  thr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lead_q <= '0;
      else if (load_i) lead_q <= lead_i;
   end

   always_comb begin
      thr = CNT_W'(MOD_DELAY_US - (int'(lead_q) + 1) * STEP_US);
   end

   assign en_o = active_i & ~kill_i & (count_i >= thr);

   assert_lead_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(lead_q));
endmodule

// File: rtl/txpa_sequencer.sv
module txpa_sequencer #(
   parameter int unsigned MOD_DELAY_US = 16,
   parameter int unsigned LEAD_W       = 2,
   parameter int unsigned STEP_US      = 2,
   parameter bit          EXT_FROM_BUF = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              us_tick_i,
   input  logic              trig_i,
   input  logic              frame_done_i,
   input  logic [LEAD_W-1:0] buf_lead_i,
   input  logic [LEAD_W-1:0] pa_lead_i,
   output logic              state_o,
   output logic              pa_buf_en_o,
   output logic              pa_en_o,
   output logic              mod_en_o,
   output logic              ext_pa_p_o,
   output logic              ext_pa_n_o
);
   import txpa_pkg::*;

   localparam int unsigned CNT_W = $clog2(MOD_DELAY_US + 1);
   localparam int unsigned N_CH  = 2;

   if (LEAD_W < 1) begin : g_bad_w
      $error("txpa_sequencer: LEAD_W must be at least 1");
   end

   txpa_state_e      state_q;
   logic             trig_rise;
   logic             start;
   logic             busy;
   logic [CNT_W-1:0] count;
   logic             at_mod;
   logic [LEAD_W-1:0] lead_in [N_CH];
   logic [N_CH-1:0]  ch_en;
   logic             ext_src;

   txpa_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .level_i(trig_i),
      .rise_o (trig_rise)
   );

   assign busy  = (state_q == ST_BUSY_TX);
   assign start = (state_q == ST_PLL_READY) & trig_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_PLL_READY;
      else begin
         unique case (state_q)
            ST_PLL_READY: if (trig_rise)    state_q <= ST_BUSY_TX;
            ST_BUSY_TX:   if (frame_done_i) state_q <= ST_PLL_READY;
            default:                        state_q <= ST_PLL_READY;
         endcase
      end
   end

   txpa_tick_count #(.LIMIT(MOD_DELAY_US), .CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear_i(~busy),
      .run_i  (busy),
      .tick_i (us_tick_i),
      .count_o(count),
      .done_o (at_mod)
   );

   assign lead_in[0] = buf_lead_i;
   assign lead_in[1] = pa_lead_i;

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      txpa_lead_gate #(
         .LEAD_W(LEAD_W), .STEP_US(STEP_US),
         .MOD_DELAY_US(MOD_DELAY_US), .CNT_W(CNT_W)
      ) u_gate (
         .clk     (clk),
         .rst_n   (rst_n),
         .load_i  (start),
         .lead_i  (lead_in[c]),
         .count_i (count),
         .active_i(busy),
         .kill_i  (frame_done_i),
         .en_o    (ch_en[c])
      );
   end

   assign pa_buf_en_o = ch_en[0];
   assign pa_en_o     = ch_en[1];
   assign mod_en_o    = busy & ~frame_done_i & at_mod;

   if (EXT_FROM_BUF) begin : g_ext_buf
      assign ext_src = ch_en[0];
   end else begin : g_ext_pa
      assign ext_src = ch_en[1];
   end

   assign ext_pa_p_o = ext_src;
   assign ext_pa_n_o = ~ext_src;
   assign state_o    = state_q;

   assert_trig_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PLL_READY && trig_rise) |=> state_q == ST_BUSY_TX);
   assert_busy_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_BUSY_TX && !frame_done_i) |=> state_q == ST_BUSY_TX);
   assert_done_returns_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_BUSY_TX && frame_done_i) |=> state_q == ST_PLL_READY);
   assert_done_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done_i |-> (!pa_buf_en_o && !pa_en_o && !mod_en_o));
   assert_ext_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ext_pa_p_o != ext_pa_n_o);
   assert_mod_after_leads_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mod_en_o |-> (pa_buf_en_o && pa_en_o));
   assert_ready_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PLL_READY) |-> (!pa_buf_en_o && !pa_en_o && !mod_en_o));
endmodule

// File: tb/tb_txpa_sequencer.sv
module tb_txpa_sequencer;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic us_tick = 1'b0, trig = 1'b0, fdone = 1'b0;
   logic [1:0] buf_lead = 2'd0, pa_lead = 2'd0;
   logic state, buf_en, pa_en, mod_en, ext_p, ext_n;
   int n_tests = 0, n_fail = 0;

   always #10 clk = ~clk;

   txpa_sequencer dut (
      .clk(clk), .rst_n(rst_n), .us_tick_i(us_tick), .trig_i(trig),
      .frame_done_i(fdone), .buf_lead_i(buf_lead), .pa_lead_i(pa_lead),
      .state_o(state), .pa_buf_en_o(buf_en), .pa_en_o(pa_en),
      .mod_en_o(mod_en), .ext_pa_p_o(ext_p), .ext_pa_n_o(ext_n)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_outs(input string req, input int b, input int p, input int k);
      int kk;
      logic eb, ep, em;
      kk = (k > 16) ? 16 : k;
      eb = (kk >= 16 - 2 * (b + 1));
      ep = (kk >= 16 - 2 * (p + 1));
      em = (kk >= 16);
      chk({req, " R4 buf"}, {7'd0, buf_en}, {7'd0, eb});
      chk({req, " R5 pa"},  {7'd0, pa_en},  {7'd0, ep});
      chk({req, " R3 mod"}, {7'd0, mod_en}, {7'd0, em});
      chk({req, " R7 pair"}, {6'd0, ext_p, ext_n}, {6'd0, ep, ~ep});
   endtask

   task automatic tick_once();
      @(negedge clk) us_tick = 1'b1;
      @(negedge clk) us_tick = 1'b0;
   endtask

   task automatic finish_frame(input string req);
      @(negedge clk) fdone = 1'b1;
      #1;
      chk({req, " R8 drop"}, {5'd0, buf_en, pa_en, mod_en}, 8'd0);
      chk({req, " R8 pair idle"}, {6'd0, ext_p, ext_n}, 8'd1);
      @(negedge clk) fdone = 1'b0;
      chk({req, " R8 ready"}, {7'd0, state}, 8'd0);
   endtask

   initial begin
      #(200000 * 20);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      chk("R1 state", {7'd0, state}, 8'd0);
      chk("R1 enables", {5'd0, buf_en, pa_en, mod_en}, 8'd0);
      chk("R1 pair", {6'd0, ext_p, ext_n}, 8'd1);
      rst_n = 1'b1;

      for (int b = 0; b < 4; b++) begin
         for (int p = 0; p < 4; p++) begin
            @(negedge clk);
            buf_lead = 2'(b); pa_lead = 2'(p); trig = 1'b1;
            @(negedge clk);
            chk("R2 busy", {7'd0, state}, 8'd1);
            chk_outs("k0", b, p, 0);
            for (int k = 1; k <= 18; k++) begin
               @(negedge clk) us_tick = 1'b1;
               if (k == 2) trig = 1'b0;
               if (k == 5) trig = 1'b1;                 // R9 edge while busy
               if (k == 3) begin buf_lead = ~2'(b); pa_lead = ~2'(p); end // R6
               @(negedge clk) us_tick = 1'b0;
               chk("R9 still busy", {7'd0, state}, 8'd1);
               chk_outs("R6 ramp", b, p, k);
            end
            repeat (3) @(negedge clk);
            chk_outs("R10 held", b, p, 18);
            finish_frame("sweep");
            @(negedge clk);
            chk("R9 held trig no restart", {7'd0, state}, 8'd0);
            trig = 1'b0;
         end
      end

      // R10: ticks in ready are not counted
      buf_lead = 2'd0; pa_lead = 2'd0;
      repeat (5) tick_once();
      @(negedge clk) trig = 1'b1;
      @(negedge clk) trig = 1'b0;
      for (int k = 1; k <= 15; k++) tick_once();
      chk("R10 ready ticks ignored", {7'd0, mod_en}, 8'd0);
      tick_once();
      chk("R3 mod at 16", {7'd0, mod_en}, 8'd1);

      // R9: trigger edge in the same cycle as frame done
      @(negedge clk) begin fdone = 1'b1; trig = 1'b1; end
      #1;
      chk("R8 same-cycle drop", {5'd0, buf_en, pa_en, mod_en}, 8'd0);
      @(negedge clk) fdone = 1'b0;
      chk("R9 same-cycle ready", {7'd0, state}, 8'd0);
      repeat (2) @(negedge clk);
      chk("R9 same-cycle stays ready", {7'd0, state}, 8'd0);
      trig = 1'b0;
      @(negedge clk) trig = 1'b1;
      @(negedge clk);
      chk("R2 fresh edge starts", {7'd0, state}, 8'd1);
      chk_outs("R4 restart k0", 0, 0, 0);
      finish_frame("tail");

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule